// File: doc/BRIEF.md
# Adaptive Five-Way Redundancy Voter

This block takes the outputs of five identical replicated modules and produces one voted data word. It starts with all five replicas trusted. On every valid cycle it looks for a strict majority among the replicas it still trusts. Any trusted replica that disagrees with that majority is removed from the trusted set, and the block raises a reconfiguration request for it. In this way the trusted set can shrink from five to four, three and finally two, and voting continues the whole time.

Some splits have no majority. A two-against-two split among four replicas is one; it is what a single fault followed by a double fault produces. Any disagreement between the last two replicas is another. In both cases the faulty side cannot be identified, so the block raises a sticky failure flag and freezes its outputs.

When an external repair mechanism has restored a module, it pulses that module's repaired strobe. The module joins the trusted set again only after it has shown that it agrees with the vote. The block sits between the replica outputs and the logic that consumes the result. The repair mechanism reads the reconfiguration requests.

Top module: `five_way_voter`

## Requirements
- R1: After reset, all five modules are active (mask 5'b11111), no reconfiguration request is raised, the failure flag is low and the voted word is zero. Module i drives data bits [i*W +: W], and bit i of every mask refers to module i.
- R2: When all active modules agree on a valid cycle, the voted word takes their common value on the next clock edge, and the masks do not change.
- R3: With five active modules and one dissenter, the dissenter leaves the active mask, its reconfiguration request bit is set, and the majority value is output. A module is never active and requested at the same time.
- R4: With five active modules and two dissenters, both dissenters are excluded and requested together, leaving three active modules.
- R5: With four active modules, a 3-1 split excludes the single dissenter. A 2-2 split raises the failure flag.
- R6: With three active modules, a 2-1 split excludes the dissenter. Three single failures in a row therefore leave two active modules without failure, and the active count never drops below two.
- R7: With two active modules, any disagreement between them on a valid cycle raises the failure flag.
- R8: Data from excluded modules has no effect on the voted word or on the masks.
- R9: A repaired pulse on a requested module arms it for readmission. On a later valid cycle where its data equals the majority value, it becomes active again and its request clears. A repaired pulse on an active module has no effect.
- R10: Once the failure flag is set, it stays set until reset. The voted word, the active mask and the request mask then hold their values.
- R11: When the data valid input is low, the voted word and the masks do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 5*W | Replica words; module i at [i*W +: W] |
| din_vld | input | 1 | Replica words are valid this cycle |
| repaired | input | 5 | Per-module pulse: module has been restored |
| vote_out | output | W | Voted word, registered |
| active_mask | output | 5 | Modules currently in the voting set |
| recfg_req | output | 5 | Modules excluded and awaiting reconfiguration |
| sys_fail | output | 1 | Unresolvable split seen; sticky |

## Verification
A wrong active mask shows up at the ports one edge after the valid cycle that caused it. It shows directly in active_mask and recfg_req. It also shows indirectly: a later vote is swayed by a module that should have been ignored, or a later split that should have failed does not. A corrupted readmission state only becomes visible on the first valid cycle after a repaired pulse. At that point the module either rejoins too early or never rejoins, so the bench lets random repairs interleave with random faults over several thousand cycles. A failure flag that is not sticky, or a voted word that is not frozen, shows on the very next cycle after the split.

// File: rtl/five_way_voter.sv
module five_way_voter #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [5*W-1:0] din,
  input  logic           din_vld,
  input  logic [4:0]     repaired,
  output logic [W-1:0]   vote_out,
  output logic [4:0]     active_mask,
  output logic [4:0]     recfg_req,
  output logic           sys_fail
);
  localparam int N = 5;

  logic [W-1:0] word [N];
  logic [4:0]   pend;
  logic         found;
  logic [W-1:0] vsel;
  logic [4:0]   dissent, match, readmit;
  int           kact;

  for (genvar g = 0; g < N; g++) begin : g_split
    assign word[g] = din[g*W +: W];
  end

  always_comb begin
    kact  = 0;
    found = 1'b0;
    vsel  = '0;
    for (int i = 0; i < N; i++) if (active_mask[i]) kact++;
    for (int i = 0; i < N; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N; j++)
        if (active_mask[j] && word[j] == word[i]) cnt++;
      if (!found && active_mask[i] && 2*cnt > kact) begin
        found = 1'b1;
        vsel  = word[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      match[i]   = (word[i] == vsel);
      dissent[i] = active_mask[i] && !match[i];
    end
  end

  assign readmit = pend & match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote_out    <= '0;
      active_mask <= 5'b11111;
      recfg_req   <= '0;
      pend        <= '0;
      sys_fail    <= 1'b0;
    end else if (!sys_fail) begin
      pend <= pend | (repaired & recfg_req);
      if (din_vld) begin
        if (found) begin
          vote_out    <= vsel;
          active_mask <= (active_mask & ~dissent) | readmit;
          recfg_req   <= (recfg_req | dissent) & ~readmit;
          pend        <= (pend | (repaired & recfg_req)) & ~readmit;
        end else begin
          sys_fail <= 1'b1;
        end
      end
    end
  end
endmodule

module five_way_voter_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [5*W-1:0] din,
  input logic           din_vld,
  input logic [W-1:0]   vote_out,
  input logic [4:0]     active_mask,
  input logic [4:0]     recfg_req,
  input logic           sys_fail
);
  logic [W-1:0] pa, pb;
  logic         two_split;

  always_comb begin
    logic seen;
    seen = 1'b0;
    pa = '0;
    pb = '0;
    for (int i = 0; i < 5; i++) begin
      if (active_mask[i]) begin
        if (!seen) begin
          pa = din[i*W +: W];
          seen = 1'b1;
        end else begin
          pb = din[i*W +: W];
        end
      end
    end
    two_split = ($countones(active_mask) == 2) && (pa != pb);
  end

  assert_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask & recfg_req) == 5'b0);
  assert_min_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_mask) >= 2);
  assert_pair_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && two_split) |=> sys_fail);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fail |=> sys_fail);
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_fail |=> ($stable(vote_out) && $stable(active_mask) && $stable(recfg_req)));
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> ($stable(vote_out) && $stable(active_mask)));
endmodule

bind five_way_voter five_way_voter_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
  .vote_out(vote_out), .active_mask(active_mask),
  .recfg_req(recfg_req), .sys_fail(sys_fail)
);

// File: tb/five_way_voter_tb_top.sv
module five_way_voter_tb_top;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [5*W-1:0] din = '0;
  logic           din_vld = 1'b0;
  logic [4:0]     repaired = '0;
  logic [W-1:0]   vote_out;
  logic [4:0]     active_mask, recfg_req;
  logic           sys_fail;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_vote;
  logic [4:0]   m_act, m_req, m_pend;
  logic         m_fail;

  always #2 clk = ~clk;

  five_way_voter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .repaired(repaired),
    .vote_out(vote_out), .active_mask(active_mask), .recfg_req(recfg_req),
    .sys_fail(sys_fail)
  );

  function automatic logic [5*W-1:0] pk(input logic [W-1:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction

  task automatic m_reset();
    m_vote = '0; m_act = 5'b11111; m_req = '0; m_pend = '0; m_fail = 1'b0;
  endtask

  task automatic m_step(input logic [5*W-1:0] d, input logic v, input logic [4:0] rep);
    logic [4:0] np;
    logic       got;
    logic [W-1:0] mv;
    int k;
    if (m_fail) return;
    np = m_pend | (rep & m_req);
    if (!v) begin m_pend = np; return; end
    k = $countones(m_act);
    got = 1'b0; mv = '0;
    for (int c = 0; c < 5; c++) begin
      int agree = 0;
      if (!m_act[c]) continue;
      for (int j = 0; j < 5; j++)
        if (m_act[j] && d[j*W +: W] == d[c*W +: W]) agree++;
      if (agree * 2 > k && !got) begin got = 1'b1; mv = d[c*W +: W]; end
    end
    if (!got) begin m_fail = 1'b1; return; end
    begin
      logic [4:0] bad, back;
      for (int j = 0; j < 5; j++) begin
        bad[j]  = m_act[j] && d[j*W +: W] != mv;
        back[j] = m_pend[j] && d[j*W +: W] == mv;
      end
      m_vote = mv;
      m_act  = (m_act & ~bad) | back;
      m_req  = (m_req | bad) & ~back;
      m_pend = np & ~back;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (vote_out !== m_vote || active_mask !== m_act || recfg_req !== m_req || sys_fail !== m_fail) begin
      errors++;
      $display("FAIL %s: got vote=%h act=%b req=%b fail=%b, expected vote=%h act=%b req=%b fail=%b",
               tag, vote_out, active_mask, recfg_req, sys_fail, m_vote, m_act, m_req, m_fail);
    end
  endtask

  task automatic cyc(input logic [5*W-1:0] d, input logic v, input logic [4:0] rep, input string tag);
    din = d; din_vld = v; repaired = rep;
    @(posedge clk);
    m_step(d, v, rep);
    @(negedge clk);
    din_vld = 1'b0; repaired = '0;
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; din_vld = 1'b0; repaired = '0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_reset();
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    @(negedge clk);
    do_reset("R1 reset state");

    cyc(pk(8'h11,8'h11,8'h11,8'h11,8'h11), 1, 0, "R2 unanimous");
    cyc(pk(8'h22,8'h22,8'h99,8'h22,8'h22), 1, 0, "R3 single dissent of five");
    cyc(pk(8'h33,8'h33,8'h55,8'h33,8'h33), 1, 0, "R8 excluded data ignored");
    cyc(pk(8'h44,8'h66,8'h00,8'h66,8'h66), 1, 0, "R5 3-1 split of four");
    cyc(pk(8'h66,8'h77,8'hAA,8'h77,8'h10), 1, 0, "R6 2-1 split of three");
    cyc(pk(8'h01,8'h05,8'h02,8'h06,8'h03), 0, 5'b00010, "R11 invalid cycle, R9 repaired on active");
    cyc(pk(8'h01,8'h07,8'h02,8'h07,8'h03), 1, 5'b00100, "R9 arm module 2");
    cyc(pk(8'h01,8'h08,8'hEE,8'h08,8'h03), 1, 0, "R9 mismatch keeps excluded");
    cyc(pk(8'h01,8'h09,8'h09,8'h09,8'h03), 1, 0, "R9 readmit on match");

    do_reset("R1 reset again");
    cyc(pk(8'h12,8'hF0,8'h12,8'hF1,8'h12), 1, 0, "R4 double dissent of five");
    cyc(pk(8'h13,8'hF0,8'h13,8'hF1,8'h13), 1, 0, "R8 after double");

    do_reset("R1 reset");
    cyc(pk(8'hC0,8'h21,8'h21,8'h21,8'h21), 1, 0, "R3 single first");
    cyc(pk(8'hC0,8'h31,8'h31,8'h32,8'h32), 1, 0, "R5 2-2 split fails");
    cyc(pk(8'h40,8'h40,8'h40,8'h40,8'h40), 1, 0, "R10 sticky hold");
    cyc(pk(8'h41,8'h41,8'h41,8'h41,8'h41), 1, 5'b00001, "R10 frozen");

    do_reset("R1 reset");
    cyc(pk(8'h50,8'h51,8'h51,8'h51,8'h51), 1, 0, "R6 first single");
    cyc(pk(8'h50,8'h52,8'h53,8'h52,8'h52), 1, 0, "R6 second single");
    cyc(pk(8'h50,8'h54,8'h53,8'h54,8'h55), 1, 0, "R6 third single");
    cyc(pk(8'h50,8'h56,8'h53,8'h57,8'h55), 1, 0, "R7 pair disagreement");

    do_reset("R1 reset before random");
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] base;
      logic [5*W-1:0] d;
      logic [4:0] rep;
      int r;
      base = W'($urandom);
      d = {5{base}};
      r = $urandom % 24;
      if (r < 3) begin
        for (int f = 0; f <= r; f++) begin
          int m = $urandom % 5;
          d[m*W +: W] = base ^ W'(1 + $urandom % 255);
        end
      end
      for (int b = 0; b < 5; b++) rep[b] = ($urandom % 12) == 0;
      cyc(d, ($urandom % 8) != 0, rep, "R2 R3 R4 R5 R9 random");
      if (m_fail && ($urandom % 4) == 0) do_reset("R1 random reset");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule